// File: doc/BRIEF.md
# Dual-Granularity SPI Clock Divider

This block derives the serial clock of an SPI controller from its reference clock and tells the shift engine when to drive and when to capture each bit. A single granularity bit selects how the divide ratio is formed. In fine mode, a 4-bit low field and an 8-bit extension field form a linear ratio from 1 to 4096. In coarse mode, the low field alone selects a power-of-two ratio up to 32768. The polarity bit sets the level at which the clock rests. The phase bit chooses whether the first or the second edge of each bit is the capture edge.

The configuration is copied into the block only while the channel enable is low, and it takes effect once the channel is enabled. A start pulse begins a run of bit periods with the internal counter at zero. A stop request ends the run at the close of the bit period in progress. Dropping the channel enable aborts the run at once. All pins are plain control and status signals, because no data stream passes through the block.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `fine_gran`=1, one bit period lasts N = {`div_ext`,`div_lo`}+1 reference cycles (N from 1 to 4096).
- R2: With `fine_gran`=0, N = 2^`div_lo` (up to 32768), and `div_ext` has no effect.
- R3: While `busy` is low, `sclk` equals the captured polarity. After reset, that level is 0.
- R4: For N>1, each bit period begins with ceil(N/2) cycles at the idle level and ends with floor(N/2) cycles at the opposite level. The first leading edge therefore comes ceil(N/2) cycles after the clock edge that accepts start.
- R5: `lead` and `trail` are internal one-cycle pulses, asserted in the cycle in which `sclk` first shows the non-idle level and the idle level, respectively. With `cpha`=0, `sample`=lead and `launch`=trail. With `cpha`=1, the two are swapped.
- R6: With N=1, while running, `sclk` sits at the idle level while the reference clock is high and at the opposite level while it is low. Both lead and trail pulse in every bit.
- R7: A stop request that arrives while running takes effect on the final cycle of the current bit. `busy` falls and `sclk` returns to idle on that edge, and the trailing strobe is given on it.
- R8: The fields `fine_gran`, `div_lo`, `div_ext`, `cpol` and `cpha` are captured only on edges where `chan_en` is 0. Changes made while the channel is enabled have no effect.
- R9: `start` is ignored while `chan_en` is 0 or while `busy` is 1.
- R10: When `chan_en` is 0 at an edge during a run, `busy`, `launch` and `sample` are 0 and `sclk` is idle after that edge.
- R11: While reset is active, `busy`, `launch`, `sample` and `sclk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; configuration is captured while it is low |
| fine_gran | input | 1 | 1 selects the linear ratio, 0 selects the power-of-two ratio |
| div_lo | input | LO_W (4) | Low divider field |
| div_ext | input | EXT_W (8) | Extension field, used in fine mode only |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: capture on the first edge; 1: capture on the second edge |
| start | input | 1 | Begins a run of bit periods |
| stop | input | 1 | Requests the end of the run at the next bit boundary |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | Strobe for driving the next bit |
| sample | output | 1 | Strobe for capturing the current bit |
| busy | output | 1 | A run is in progress |

## Verification
The hardest case to reach is a stop request that coincides with the last cycle of a bit. This happens at every edge when N is 1, and only at a chosen cycle when N is larger. The bench raises stop in the first cycle of the final bit of each transfer, for every ratio from 1 to 16 and for the power-of-two ratios up to 512, so that both the pending path and the immediate path are exercised. The long end of each range (4096 and 32768) runs for a single bit. Configuration changes and a second start are injected mid-run to show that they have no effect.

// File: rtl/sclkdiv_pkg.sv
`timescale 1ns/1ps
package sclkdiv_pkg;
  // width holding the largest ratio of either granularity
  function automatic int ratio_width(input int lo_w, input int ext_w);
    int lin;
    int pow;
    lin = lo_w + ext_w;
    pow = (1 << lo_w) - 1;
    return ((lin > pow) ? lin : pow) + 1;
  endfunction
endpackage

// File: rtl/sclkdiv_cfg.sv
`timescale 1ns/1ps
module sclkdiv_cfg
  import sclkdiv_pkg::*;
#(
  parameter int LO_W  = 4,
  parameter int EXT_W = 8,
  parameter int RW    = ratio_width(LO_W, EXT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             fine_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic [RW-1:0]    ratio,
  output logic [RW-1:0]    half_idle,
  output logic             ratio_one,
  output logic             cpol,
  output logic             cpha
);
  localparam int PAD = RW - LO_W - EXT_W;

  logic [RW-1:0] lin_ratio, pow_ratio, new_ratio;

  assign lin_ratio = {{PAD{1'b0}}, ext_i, lo_i} + RW'(1);
  assign pow_ratio = RW'(1) << lo_i;
  assign new_ratio = fine_i ? lin_ratio : pow_ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio     <= RW'(1);
      half_idle <= RW'(1);
      ratio_one <= 1'b1;
      cpol      <= 1'b0;
      cpha      <= 1'b0;
    end else if (!chan_en) begin
      ratio     <= new_ratio;
      half_idle <= new_ratio - (new_ratio >> 1);
      ratio_one <= (new_ratio == RW'(1));
      cpol      <= cpol_i;
      cpha      <= cpha_i;
    end
  end

  // R8: captured settings stay frozen across enabled edges
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chan_en) |-> ($stable(ratio) && $stable(cpol) && $stable(cpha)));
endmodule

// File: rtl/sclkdiv_timer.sv
`timescale 1ns/1ps
module sclkdiv_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          start,
  input  logic          stop,
  input  logic [RW-1:0] ratio,
  output logic          run,
  output logic          run_nxt,
  output logic [RW-1:0] cnt_nxt,
  output logic          bit_end
);
  logic [RW-1:0] cnt_q;
  logic          pend_q, pend_nxt;

  assign bit_end = run && (cnt_q == ratio - RW'(1));

  always_comb begin
    run_nxt  = run;
    cnt_nxt  = cnt_q;
    pend_nxt = pend_q;
    if (!chan_en) begin
      run_nxt  = 1'b0;
      cnt_nxt  = '0;
      pend_nxt = 1'b0;
    end else if (!run) begin
      if (start) begin
        run_nxt  = 1'b1;
        cnt_nxt  = '0;
        pend_nxt = 1'b0;
      end
    end else if (bit_end) begin
      cnt_nxt = '0;
      if (stop || pend_q) begin
        run_nxt  = 1'b0;
        pend_nxt = 1'b0;
      end
    end else begin
      cnt_nxt = cnt_q + RW'(1);
      if (stop) pend_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      run    <= run_nxt;
      cnt_q  <= cnt_nxt;
      pend_q <= pend_nxt;
    end
  end

  // R1: the counter never reaches the ratio while running
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < ratio));
  // R9: a run only begins from an accepted start
  p_start_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(start) && $past(chan_en)));
  // R7: a run that was not aborted ends only at a bit boundary
  p_stop_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && $past(chan_en)) |-> $past(bit_end));
endmodule

// File: rtl/sclkdiv_edges.sv
`timescale 1ns/1ps
module sclkdiv_edges #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          ratio_one,
  input  logic [RW-1:0] half_idle,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          run,
  input  logic          run_nxt,
  input  logic [RW-1:0] cnt_nxt,
  input  logic          bit_end,
  output logic          sclk,
  output logic          launch,
  output logic          sample
);
  logic act_q, lead_q, trail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      act_q   <= run_nxt && !ratio_one && (cnt_nxt >= half_idle);
      lead_q  <= run_nxt && (ratio_one || (cnt_nxt == half_idle));
      trail_q <= bit_end && chan_en;
    end
  end

  // ratio one: the low half of each reference cycle is the active half
  assign sclk   = cpol ^ (ratio_one ? (run & ~clk) : act_q);
  assign launch = cpha ? lead_q : trail_q;
  assign sample = cpha ? trail_q : lead_q;

  // R3: idle level whenever no run is in progress
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sclk == cpol));
  // R5: a leading strobe only occurs inside a run
  p_lead_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> run);
  // R4: above ratio one, the two edges of a bit never share a cycle
  p_edges_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_one |-> !(lead_q && trail_q));
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen
  import sclkdiv_pkg::*;
#(
  parameter int LO_W  = 4,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             fine_gran,
  input  logic [LO_W-1:0]  div_lo,
  input  logic [EXT_W-1:0] div_ext,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             start,
  input  logic             stop,
  output logic             sclk,
  output logic             launch,
  output logic             sample,
  output logic             busy
);
  localparam int RW = ratio_width(LO_W, EXT_W);

  logic [RW-1:0] ratio, half_idle, cnt_nxt;
  logic          ratio_one, cpol_q, cpha_q;
  logic          run, run_nxt, bit_end;

  sclkdiv_cfg #(.LO_W(LO_W), .EXT_W(EXT_W), .RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .fine_i(fine_gran), .lo_i(div_lo), .ext_i(div_ext),
    .cpol_i(cpol), .cpha_i(cpha),
    .ratio(ratio), .half_idle(half_idle), .ratio_one(ratio_one),
    .cpol(cpol_q), .cpha(cpha_q)
  );

  sclkdiv_timer #(.RW(RW)) u_timer (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .start(start), .stop(stop), .ratio(ratio),
    .run(run), .run_nxt(run_nxt), .cnt_nxt(cnt_nxt), .bit_end(bit_end)
  );

  sclkdiv_edges #(.RW(RW)) u_edges (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .ratio_one(ratio_one), .half_idle(half_idle),
    .cpol(cpol_q), .cpha(cpha_q),
    .run(run), .run_nxt(run_nxt), .cnt_nxt(cnt_nxt), .bit_end(bit_end),
    .sclk(sclk), .launch(launch), .sample(sample)
  );

  assign busy = run;
endmodule

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/1ps
module test_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_en = 1'b0, fine_gran = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic       start = 1'b0, stop = 1'b0;
  logic [3:0] div_lo = '0;
  logic [7:0] div_ext = '0;
  logic       sclk, launch, sample, busy;
  int         n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  spi_sclk_gen i_spi_sclk_gen (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fine_gran(fine_gran),
    .div_lo(div_lo), .div_ext(div_ext), .cpol(cpol), .cpha(cpha),
    .start(start), .stop(stop),
    .sclk(sclk), .launch(launch), .sample(sample), .busy(busy)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // one transfer of nbits bits; stop raised in the first cycle of the last bit
  task automatic xfer(input logic f, input logic [3:0] lo, input logic [7:0] ext,
                      input logic pol, input logic pha, input int nbits,
                      input bit scramble, input bit poke);
    int n, l, tot;
    string tag;
    n   = f ? (int'({ext, lo}) + 1) : (1 << lo);
    l   = n - n / 2;
    tot = nbits * n;
    tag = (n == 1) ? "R6" : (scramble ? "R8" : (f ? "R1" : "R2"));
    @(negedge clk);
    chan_en = 1'b0; fine_gran = f; div_lo = lo; div_ext = ext;
    cpol = pol; cpha = pha; start = 1'b0; stop = 1'b0;
    @(negedge clk);
    chan_en = 1'b1; start = 1'b1;
    if (scramble) begin
      fine_gran = ~f; div_lo = lo ^ 4'h5; div_ext = ext ^ 8'h3c;
      cpol = ~pol; cpha = ~pha;
    end
    @(posedge clk);
    for (int k = 0; k <= tot + 2; k++) begin
      logic be, le, te, shi, slo;
      int   pos;
      pos = k % n;
      be  = (k < tot);
      le  = be && (pos == (l % n));
      te  = (k > 0) && (pos == 0) && (k <= tot);
      shi = (n == 1) ? pol : (pol ^ (be && pos >= l));
      slo = (n == 1) ? (pol ^ be) : shi;
      #5;
      chk({tag, be ? " R4" : " R3"}, "sclk high half", sclk, shi);
      chk({tag, " R7"}, "busy", busy, be);
      chk({tag, " R5"}, "launch", launch, pha ? le : te);
      chk({tag, " R5"}, "sample", sample, pha ? te : le);
      #5;
      start = poke && (k == 1);
      stop  = (k == (nbits - 1) * n);
      #5;
      chk({tag, be ? " R4" : " R3"}, "sclk low half", sclk, slo);
      @(posedge clk);
    end
    @(negedge clk);
    stop = 1'b0; start = 1'b0; chan_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // R11: reset state
    #15;
    chk("R11", "sclk", sclk, 1'b0);
    chk("R11", "busy", busy, 1'b0);
    chk("R11", "launch", launch, 1'b0);
    chk("R11", "sample", sample, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1, R6: every fine ratio 1..16, all four clock modes
    for (int lo = 0; lo < 16; lo++)
      for (int m = 0; m < 4; m++)
        xfer(1'b1, 4'(lo), 8'h00, m[1], m[0], 2, 1'b0, 1'b0);
    // R1: extension field in use
    xfer(1'b1, 4'h9, 8'h01, 1'b0, 1'b1, 2, 1'b0, 1'b0);
    xfer(1'b1, 4'hf, 8'h03, 1'b1, 1'b0, 2, 1'b0, 1'b0);
    xfer(1'b1, 4'hf, 8'hff, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    // R2: power-of-two ratios with a nonzero extension that must be ignored
    for (int lo = 0; lo < 10; lo++)
      for (int m = 0; m < 4; m++)
        xfer(1'b0, 4'(lo), 8'ha5, m[1], m[0], 2, 1'b0, 1'b0);
    xfer(1'b0, 4'hf, 8'h5a, 1'b1, 1'b1, 1, 1'b0, 1'b0);
    // R8 and R9: inputs changed while enabled, plus a second start mid-run
    xfer(1'b1, 4'h3, 8'h00, 1'b0, 1'b1, 3, 1'b1, 1'b1);
    xfer(1'b0, 4'h2, 8'h11, 1'b1, 1'b0, 3, 1'b1, 1'b1);
    xfer(1'b1, 4'h0, 8'h00, 1'b0, 1'b0, 4, 1'b1, 1'b1);

    // R9: start with the channel disabled does nothing
    @(negedge clk); chan_en = 1'b0; start = 1'b1; cpol = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      chk("R9", "busy while disabled", busy, 1'b0);
      chk("R9", "sclk while disabled", sclk, 1'b1);
    end
    @(negedge clk); start = 1'b0;

    // R10: abort by dropping the enable mid-bit (ratio 8, polarity 1)
    @(negedge clk); fine_gran = 1'b1; div_lo = 4'h7; div_ext = 8'h00; cpol = 1'b1; cpha = 1'b0;
    @(negedge clk); chan_en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    chan_en = 1'b0;
    @(posedge clk); #5;
    chk("R10", "busy after abort", busy, 1'b0);
    chk("R10", "sclk after abort", sclk, 1'b1);
    chk("R10", "launch after abort", launch, 1'b0);
    chk("R10", "sample after abort", sample, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule